// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external controller reach on-chip program and data memory through a 16-bit multiplexed address/data bus. The bus runs independently of the core clock. The host first performs an address phase. The bus then carries a 14-bit word address, a one-bit memory-space flag and a guard bit that must be zero. After that the host issues any number of read or write strobes. The port walks through consecutive locations on its own, so a sequential block needs only its start address.

Every host strobe passes through a two-flop synchronizer into the core clock domain. An edge detector turns it into a single request. The sequencer then runs one memory cycle and holds an active-high ready line low from the accepted request until the access has finished. Program words are 24 bits wide, so each one takes two bus transfers. The upper 16 bits move first, and the low byte moves second in bits 7:0. A range of data-memory addresses at the top of the space holds control registers, and the port refuses to write it.

Top module: `host_mem_port`

## Requirements
- R1: After reset, `host_ack` is 1, `host_rd_data` is 0, `pm_en` and `dm_en` are 0, and the latched address is 0 with data space selected.
- R2: A falling edge of `host_latch` while `host_sel_n` is low loads the address from bus bits 13:0 and the space flag from bit 14 (1 selects program memory, 0 selects data memory). The load is ignored when bus bit 15 is 1.
- R3: A strobe that goes low at most half a clock before a rising edge raises the memory enable, and drops `host_ack`, on the third rising edge after it. `host_ack` returns to 1 on the fifth rising edge, and read data is valid at that point.
- R4: A data-space write stores bus bits 15:0 at the latched address with a single memory write.
- R5: A data-space read returns the addressed word on `host_rd_data` when `host_ack` returns.
- R6: The latched address increases by one after each completed data-space access and wraps from 0x3FFF to 0.
- R7: In program space, the first write transfer holds the upper 16 bits and touches no memory. The second write transfer performs one 24-bit write of {held bits, bus bits 7:0}. The address advances only after the second transfer.
- R8: In program space, the first read transfer performs one memory read and returns bits 23:8. The second read transfer returns {8'h00, bits 7:0} without a memory access. The address advances only after the second transfer.
- R9: Data-space writes at addresses at or above `CTRL_LO` (default 0x3FE0) leave memory unchanged, but still complete and still advance the address. Reads from that range are allowed.
- R10: Strobes are ignored while `host_ack` is low, and while `host_sel_n` is high.
- R11: An address phase does not change `host_rd_data` and starts no memory access. The latched address can be observed only through the accesses that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Port select, active low, asynchronous |
| host_latch | input | 1 | Address-phase strobe; its falling edge latches the address |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_bus_i | input | 16 | Multiplexed address/data from the host |
| host_ack | output | 1 | Ready: 1 when idle, 0 while an access is in progress |
| host_rd_data | output | 16 | Read data returned to the host |
| pm_en | output | 1 | Program memory enable |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 14 | Program memory word address |
| pm_wdata | output | 24 | Program memory write data |
| pm_rdata | input | 24 | Program memory read data, one cycle after the enable |
| dm_en | output | 1 | Data memory enable |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 14 | Data memory word address |
| dm_wdata | output | 16 | Data memory write data |
| dm_rdata | input | 16 | Data memory read data, one cycle after the enable |

## Verification
The bench drives every host strobe at a falling clock edge. By R3, the memory enable is then due at the falling edge after the third rising edge, and ready plus read data are due after the fifth. Every transfer task samples at exactly those points, and one directed test checks each intermediate cycle of a write. Address latches are sampled only after the latch-strobe fall has crossed both synchronizer stages and one more edge. The tests for ignored strobes count memory enables across the whole window. They then check, through a following read, that the address moved only as expected.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  localparam int STB_N = 4;
  localparam int STB_SEL = 0;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 2;
  localparam int STB_LAT = 3;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/hmp_edge.sv
module hmp_edge #(
  parameter int               WIDTH     = 3,
  parameter logic [WIDTH-1:0] FALL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] pulse_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (FALL_MASK[i]) begin : g_fall
      assign pulse_o[i] = prev_q[i] & ~level_i[i];
    end else begin : g_rise
      assign pulse_o[i] = level_i[i] & ~prev_q[i];
    end
  end

  // R3
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(pulse_o & $past(pulse_o))));
endmodule

// File: rtl/hmp_addr.sv
module hmp_addr #(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_ev,
  input  logic              idle,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              space_pm,
  output logic              latch_ok
);
  localparam int SPACE_BIT = ADDR_W;
  localparam int GUARD_BIT = BUS_W - 1;

  assign latch_ok = latch_ev & idle & ~bus_in[GUARD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      space_pm <= 1'b0;
    end else if (latch_ok) begin
      addr     <= bus_in[ADDR_W-1:0];
      space_pm <= bus_in[SPACE_BIT];
    end else if (step) begin
      addr     <= addr + 1'b1;
    end
  end

  // R2
  guard_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_ev && idle && bus_in[GUARD_BIT]) |=> $stable(addr));
  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    latch_ok |=> (addr == $past(bus_in[ADDR_W-1:0])));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !latch_ok) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/hmp_seq.sv
module hmp_seq
  import hmp_pkg::*;
#(
  parameter int               ADDR_W  = 14,
  parameter int               BUS_W   = 16,
  parameter int               PM_W    = 24,
  parameter int               DM_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_LO = 14'h3FE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ev,
  input  logic              wr_ev,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              space_pm,
  input  logic              latch_ok,
  output logic              idle,
  output logic              step,
  output logic              host_ack,
  output logic [BUS_W-1:0]  rd_data,
  output logic              pm_en,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [PM_W-1:0]   pm_wdata,
  input  logic [PM_W-1:0]   pm_rdata,
  output logic              dm_en,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [DM_W-1:0]   dm_wdata,
  input  logic [DM_W-1:0]   dm_rdata
);
  localparam int PM_LO_W = PM_W - BUS_W;
  localparam int PAD_W   = BUS_W - PM_LO_W;

  seq_state_t         state;
  logic               is_wr;
  logic               half;
  logic [BUS_W-1:0]   hold_hi;
  logic [PM_LO_W-1:0] lo_hold;
  logic               go;
  logic               prot;

  assign idle = (state == ST_IDLE);
  assign go   = idle & (rd_ev | wr_ev);
  assign prot = (addr >= CTRL_LO);
  assign step = (state == ST_FIN) & (~space_pm | half);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      host_ack <= 1'b1;
      is_wr    <= 1'b0;
      half     <= 1'b0;
      hold_hi  <= '0;
      lo_hold  <= '0;
      rd_data  <= '0;
      pm_en    <= 1'b0;
      pm_we    <= 1'b0;
      pm_addr  <= '0;
      pm_wdata <= '0;
      dm_en    <= 1'b0;
      dm_we    <= 1'b0;
      dm_addr  <= '0;
      dm_wdata <= '0;
    end else begin
      pm_en <= 1'b0;
      pm_we <= 1'b0;
      dm_en <= 1'b0;
      dm_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (latch_ok) half <= 1'b0;
          if (go) begin
            state    <= ST_MEM;
            host_ack <= 1'b0;
            is_wr    <= wr_ev;
            if (space_pm) begin
              pm_addr <= addr;
              if (wr_ev) begin
                if (!half) begin
                  hold_hi <= bus_in;
                end else begin
                  pm_en    <= 1'b1;
                  pm_we    <= 1'b1;
                  pm_wdata <= {hold_hi, bus_in[PM_LO_W-1:0]};
                end
              end else if (!half) begin
                pm_en <= 1'b1;
              end
            end else begin
              dm_en    <= 1'b1;
              dm_we    <= wr_ev & ~prot;
              dm_addr  <= addr;
              dm_wdata <= bus_in[DM_W-1:0];
            end
          end
        end
        ST_MEM: state <= ST_FIN;
        ST_FIN: begin
          state    <= ST_IDLE;
          host_ack <= 1'b1;
          if (!is_wr) begin
            if (space_pm) begin
              if (!half) begin
                rd_data <= pm_rdata[PM_W-1 -: BUS_W];
                lo_hold <= pm_rdata[PM_LO_W-1:0];
              end else begin
                rd_data <= {{PAD_W{1'b0}}, lo_hold};
              end
            end else begin
              rd_data <= BUS_W'(dm_rdata);
            end
          end
          if (space_pm) half <= ~half;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> !host_ack);
  // R3
  ack_back_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |=> host_ack);
  // R9
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> (dm_addr < CTRL_LO));
  // R10
  one_space_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pm_en, dm_en}));
  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_en || dm_en) |-> !host_ack);
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int               ADDR_W  = 14,
  parameter int               BUS_W   = 16,
  parameter int               PM_W    = 24,
  parameter int               DM_W    = 16,
  parameter int               SYNC_N  = 2,
  parameter logic [ADDR_W-1:0] CTRL_LO = 14'h3FE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_latch,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [BUS_W-1:0]  host_bus_i,
  output logic              host_ack,
  output logic [BUS_W-1:0]  host_rd_data,
  output logic              pm_en,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [PM_W-1:0]   pm_wdata,
  input  logic [PM_W-1:0]   pm_rdata,
  output logic              dm_en,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [DM_W-1:0]   dm_wdata,
  input  logic [DM_W-1:0]   dm_rdata
);
  logic [STB_N-1:0]  stb_raw;
  logic [STB_N-1:0]  stb_s;
  logic [2:0]        lvl;
  logic [2:0]        pulse;
  logic              latch_ev, rd_ev, wr_ev;
  logic              idle, step, latch_ok, space_pm;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    stb_raw          = '0;
    stb_raw[STB_SEL] = ~host_sel_n;
    stb_raw[STB_RD]  = ~host_rd_n;
    stb_raw[STB_WR]  = ~host_wr_n;
    stb_raw[STB_LAT] = host_latch;
  end

  hmp_sync #(.WIDTH(STB_N), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .async_i(stb_raw), .sync_o(stb_s)
  );

  assign lvl = {stb_s[STB_LAT],
                stb_s[STB_SEL] & stb_s[STB_WR],
                stb_s[STB_SEL] & stb_s[STB_RD]};

  hmp_edge #(.WIDTH(3), .FALL_MASK(3'b100)) u_edge (
    .clk(clk), .rst(rst), .level_i(lvl), .pulse_o(pulse)
  );

  assign latch_ev = pulse[2] & stb_s[STB_SEL];
  assign wr_ev    = pulse[1];
  assign rd_ev    = pulse[0];

  hmp_addr #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_addr (
    .clk(clk), .rst(rst), .latch_ev(latch_ev), .idle(idle),
    .bus_in(host_bus_i), .step(step), .addr(addr),
    .space_pm(space_pm), .latch_ok(latch_ok)
  );

  hmp_seq #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PM_W(PM_W), .DM_W(DM_W), .CTRL_LO(CTRL_LO)
  ) u_seq (
    .clk(clk), .rst(rst), .rd_ev(rd_ev), .wr_ev(wr_ev), .bus_in(host_bus_i),
    .addr(addr), .space_pm(space_pm), .latch_ok(latch_ok),
    .idle(idle), .step(step), .host_ack(host_ack), .rd_data(host_rd_data),
    .pm_en(pm_en), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata),
    .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata)
  );

  // R1
  reset_ready_chk: assert property (@(posedge clk)
    $past(rst) |-> (host_ack && !pm_en && !dm_en));
endmodule

// File: tb/host_mem_port_tb_top.sv
`timescale 1ns/1ps
module host_mem_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel_n = 1'b1, host_latch = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [15:0] host_bus_i = '0;
  logic        host_ack;
  logic [15:0] host_rd_data;
  logic        pm_en, pm_we, dm_en, dm_we;
  logic [13:0] pm_addr, dm_addr;
  logic [23:0] pm_wdata, pm_rdata;
  logic [15:0] dm_wdata, dm_rdata;

  always #2.5 clk = ~clk;

  host_mem_port dut_i (
    .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_latch(host_latch),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_bus_i(host_bus_i),
    .host_ack(host_ack), .host_rd_data(host_rd_data),
    .pm_en(pm_en), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata), .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata)
  );

  // Memory models with a bench-side preload path
  logic [15:0] dm_mem [256];
  logic [23:0] pm_mem [256];
  logic        pre_dm = 1'b0, pre_pm = 1'b0;
  logic [7:0]  pre_a = '0;
  logic [23:0] pre_d = '0;
  int dm_acc = 0, dm_wcnt = 0, pm_rcnt = 0, pm_wcnt = 0;

  always @(posedge clk) begin
    if (pre_dm) dm_mem[pre_a] <= pre_d[15:0];
    else if (dm_en) begin
      if (dm_we) dm_mem[dm_addr[7:0]] <= dm_wdata;
      dm_rdata <= dm_mem[dm_addr[7:0]];
    end
    if (pre_pm) pm_mem[pre_a] <= pre_d;
    else if (pm_en) begin
      if (pm_we) pm_mem[pm_addr[7:0]] <= pm_wdata;
      pm_rdata <= pm_mem[pm_addr[7:0]];
    end
    if (dm_en) dm_acc++;
    if (dm_en && dm_we) dm_wcnt++;
    if (pm_en && !pm_we) pm_rcnt++;
    if (pm_en && pm_we) pm_wcnt++;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic preload(input bit pm, input logic [7:0] a, input logic [23:0] d);
    pre_a = a; pre_d = d; pre_dm = !pm; pre_pm = pm;
    @(negedge clk);
    pre_dm = 1'b0; pre_pm = 1'b0;
  endtask

  task automatic do_latch(input logic [15:0] v);
    host_sel_n = 1'b0; host_latch = 1'b1; host_bus_i = v;
    repeat (4) @(negedge clk);
    host_latch = 1'b0;
    repeat (4) @(negedge clk);
    host_sel_n = 1'b1; host_bus_i = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_op(input bit wr, input logic [15:0] d, output logic [15:0] q);
    host_sel_n = 1'b0; host_bus_i = d;
    if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    q = host_rd_data;
    host_wr_n = 1'b1; host_rd_n = 1'b1; host_sel_n = 1'b1; host_bus_i = '0;
    repeat (4) @(negedge clk);
  endtask

  // op: 0 latch, 1 write, 2 read; {op, bus, expected read data}
  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 16'h0010, 16'h0000},
    {2'd1, 16'h1234, 16'h0000},
    {2'd1, 16'hABCD, 16'h0000},
    {2'd0, 16'h0010, 16'h0000},
    {2'd2, 16'h0000, 16'h1234},
    {2'd2, 16'h0000, 16'hABCD},
    {2'd0, 16'h4020, 16'h0000},
    {2'd1, 16'hA5B6, 16'h0000},
    {2'd1, 16'h00C7, 16'h0000},
    {2'd1, 16'h1122, 16'h0000},
    {2'd1, 16'hFF33, 16'h0000},
    {2'd0, 16'h4020, 16'h0000},
    {2'd2, 16'h0000, 16'hA5B6},
    {2'd2, 16'h0000, 16'h00C7},
    {2'd2, 16'h0000, 16'h1122},
    {2'd2, 16'h0000, 16'h0033}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    int a0, w0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack after reset", host_ack, 1);
    chk("R1 rd_data after reset", host_rd_data, 0);
    chk("R1 dm_en after reset", dm_en, 0);
    chk("R1 pm_en after reset", pm_en, 0);

    preload(0, 8'h30, 24'h3030); preload(0, 8'h50, 24'h5050);
    preload(0, 8'hE0, 24'h0E0E); preload(0, 8'hE1, 24'h0E1E);
    preload(0, 8'hFF, 24'hF0F0); preload(0, 8'h00, 24'hA0A0);
    preload(0, 8'h61, 24'h6161);

    // R1: first access after reset uses address 0 in data space
    do_op(0, 16'h0, q);
    chk("R1 reset address reads dm[0]", q, 16'hA0A0);

    // Vector table: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][33:32])
        2'd0: do_latch(VEC[i][31:16]);
        2'd1: do_op(1, VEC[i][31:16], q);
        default: begin
          do_op(0, 16'h0, q);
          chk("R5 R8 table read", q, VEC[i][15:0]);
        end
      endcase
    end
    chk("R4 dm write at 0x10", dm_mem[8'h10], 16'h1234);
    chk("R6 dm write stepped to 0x11", dm_mem[8'h11], 16'hABCD);
    chk("R7 pm word 0x20", pm_mem[8'h20], 24'hA5B6C7);
    chk("R7 pm word 0x21", pm_mem[8'h21], 24'h112233);
    chk("R7 pm write count", pm_wcnt, 2);
    chk("R8 pm read count", pm_rcnt, 2);

    // R3: cycle-exact write timing
    do_latch(16'h0040);
    host_sel_n = 1'b0; host_wr_n = 1'b0; host_bus_i = 16'h4444;
    @(posedge clk); @(negedge clk);
    chk("R3 edge1 ack", host_ack, 1);
    @(posedge clk); @(negedge clk);
    chk("R3 edge2 dm_en", dm_en, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 edge3 dm_en", dm_en, 1);
    chk("R3 edge3 ack", host_ack, 0);
    chk("R4 edge3 dm_addr", dm_addr, 14'h0040);
    @(posedge clk); @(negedge clk);
    chk("R3 edge4 ack", host_ack, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 edge5 ack", host_ack, 1);
    host_sel_n = 1'b1; host_wr_n = 1'b1; host_bus_i = '0;
    repeat (4) @(negedge clk);
    chk("R4 dm[0x40]", dm_mem[8'h40], 16'h4444);

    // R2: guard bit set -> latch ignored
    do_latch(16'h0030);
    do_latch(16'h8050);
    do_op(0, 16'h0, q);
    chk("R2 guard bit ignored", q, 16'h3030);

    // R9: protected region
    w0 = dm_wcnt;
    do_latch(16'h3FE0);
    do_op(1, 16'hDEAD, q);
    chk("R9 protected word unchanged", dm_mem[8'hE0], 16'h0E0E);
    chk("R9 no write strobe", dm_wcnt, w0);
    do_op(0, 16'h0, q);
    chk("R9 address still stepped, read allowed", q, 16'h0E1E);

    // R6: wrap
    do_latch(16'h3FFF);
    do_op(0, 16'h0, q);
    chk("R6 read at 0x3FFF", q, 16'hF0F0);
    do_op(0, 16'h0, q);
    chk("R6 wrap to 0", q, 16'hA0A0);

    // R10: read strobe during busy write is dropped
    do_latch(16'h0060);
    a0 = dm_acc;
    host_sel_n = 1'b0; host_wr_n = 1'b0; host_bus_i = 16'h6666;
    @(posedge clk); @(negedge clk);
    host_rd_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    host_sel_n = 1'b1; host_wr_n = 1'b1; host_rd_n = 1'b1; host_bus_i = '0;
    repeat (6) @(negedge clk);
    chk("R10 one access while busy", dm_acc - a0, 1);
    chk("R10 write landed", dm_mem[8'h60], 16'h6666);
    do_op(0, 16'h0, q);
    chk("R10 single step", q, 16'h6161);

    // R10: strobe without select is ignored
    a0 = dm_acc;
    host_wr_n = 1'b0; host_bus_i = 16'h7777;
    repeat (8) @(negedge clk);
    host_wr_n = 1'b1; host_bus_i = '0;
    repeat (4) @(negedge clk);
    chk("R10 unselected strobe no access", dm_acc - a0, 0);

    // R11: latch leaves read data and memory alone
    a0 = dm_acc;
    do_latch(16'h0050);
    chk("R11 rd_data kept", host_rd_data, 16'h6161);
    chk("R11 no memory access", dm_acc - a0 + pm_rcnt - 2, 0);
    do_op(0, 16'h0, q);
    chk("R11 new address in use", q, 16'h5050);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule